// File: doc/BRIEF.md
# Packet-Boundary Stream Framer

This block takes packet bodies on a 64-bit valid/ready stream. Each body's header word rides on a side-band field that is sampled with the final body beat. The framer stores body words in one queue and headers in a second queue with one entry per packet. It emits each packet as its header followed by its body words.

No word of a packet leaves the block until the whole body is stored. A downstream packet switch therefore always sees a complete packet that it can forward at one word per cycle. A packet is released as soon as its final body beat is accepted. The block does not wait for the queues to fill, so a single short packet is not stuck behind an empty pipeline.

A synchronous clear empties both queues in one cycle and returns the output to the header phase.

Top module: `pkt_framer`

## Requirements
- R1: The first output word of every packet is the header value that was present on `in_hdr` when that packet's final input beat (`in_last` = 1) was accepted.
- R2: `out_last` is 1 only on the final body word of a packet. A packet with a one-word body leaves as exactly two beats: the header with `out_last` = 0, then the body word with `out_last` = 1.
- R3: No output word of a packet appears before that packet's final body beat has been accepted at the input.
- R4: When the output is idle and `out_ready` is held at 1, the header of a packet is valid on the output in the cycle right after its final body beat is accepted. This holds even when that packet is the only one stored.
- R5: Packets leave in arrival order. Body words leave in arrival order, directly after their own header, with no word from another packet mixed in.
- R6: `in_ready` is 0 whenever either queue is full. The header queue holds 2^HDR_AW packets and the body queue holds 2^BODY_AW words.
- R7: A cycle with `clear` = 1 empties both queues. In the next cycle `out_valid` is 0 and `in_ready` is 1, and no word stored before the clear ever appears on the output.
- R8: While `out_valid` = 1 and `out_ready` = 0, the output word and `out_last` stay unchanged and `out_valid` stays 1 into the next cycle.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Synchronous flush of both queues |
| in_data | input | DATA_W | Body word |
| in_hdr | input | DATA_W | Header word, taken on the final body beat |
| in_last | input | 1 | Marks the final body beat of a packet |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| out_data | output | DATA_W | Header or body word |
| out_last | output | 1 | Final word of the framed packet |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |

## Verification
The properties assume three things about the input side. Every body fits in the body queue, so a packet never stalls half stored. Clear is raised only while no input beat is offered. The packet count tracked from the ports is reset together with the queues.

The stimulus keeps to these rules. Bodies are at most as long as the body queue, and clear is raised only with the input idle. Each input beat is held until it is accepted. Output stalls come from a free-running shift register, and the flush is exercised only between packets.

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int DATA_W  = 64,
  parameter int BODY_AW = 5,
  parameter int HDR_AW  = 3
) (
  input  logic              clk,
  input  logic              reset,
  input  logic              clear,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] in_hdr,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam int BODY_DEPTH = 1 << BODY_AW;
  localparam int HDR_DEPTH  = 1 << HDR_AW;

  logic [DATA_W:0]   body_mem [BODY_DEPTH];
  logic [DATA_W-1:0] hdr_mem  [HDR_DEPTH];
  logic [BODY_AW:0]  b_wr, b_rd;
  logic [HDR_AW:0]   h_wr, h_rd;
  logic              in_body;

  wire b_empty = (b_wr == b_rd);
  wire h_empty = (h_wr == h_rd);
  wire b_full  = (b_wr[BODY_AW] != b_rd[BODY_AW]) &&
                 (b_wr[BODY_AW-1:0] == b_rd[BODY_AW-1:0]);
  wire h_full  = (h_wr[HDR_AW] != h_rd[HDR_AW]) &&
                 (h_wr[HDR_AW-1:0] == h_rd[HDR_AW-1:0]);

  wire [DATA_W:0]   body_word = body_mem[b_rd[BODY_AW-1:0]];
  wire [DATA_W-1:0] hdr_word  = hdr_mem[h_rd[HDR_AW-1:0]];

  assign in_ready  = !b_full && !h_full;
  assign out_valid = in_body ? !b_empty : !h_empty;
  assign out_data  = in_body ? body_word[DATA_W-1:0] : hdr_word;
  assign out_last  = in_body && body_word[DATA_W];

  wire in_fire  = in_valid && in_ready;
  wire out_fire = out_valid && out_ready;
  wire body_pop = out_fire && in_body;
  wire hdr_pop  = out_fire && !in_body;

  always_ff @(posedge clk) begin
    if (in_fire) begin
      body_mem[b_wr[BODY_AW-1:0]] <= {in_last, in_data};
      if (in_last) hdr_mem[h_wr[HDR_AW-1:0]] <= in_hdr;
    end
  end

  always_ff @(posedge clk) begin
    if (reset || clear) begin
      b_wr    <= '0;
      b_rd    <= '0;
      h_wr    <= '0;
      h_rd    <= '0;
      in_body <= 1'b0;
    end else begin
      if (in_fire)            b_wr <= b_wr + 1'b1;
      if (in_fire && in_last) h_wr <= h_wr + 1'b1;
      if (body_pop)           b_rd <= b_rd + 1'b1;
      if (hdr_pop)            h_rd <= h_rd + 1'b1;
      if (hdr_pop)
        in_body <= 1'b1;
      else if (body_pop && body_word[DATA_W])
        in_body <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk #(
  parameter int DATA_W = 64,
  parameter int HDR_AW = 3
) (
  input logic              clk,
  input logic              reset,
  input logic              clear,
  input logic              in_last,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic              out_valid,
  input logic              out_ready
);
  localparam int CW = HDR_AW + 2;
  logic [CW-1:0] pending;
  logic          mid_pkt;

  always_ff @(posedge clk) begin
    if (reset || clear) begin
      pending <= '0;
      mid_pkt <= 1'b0;
    end else begin
      pending <= pending + CW'(in_valid && in_ready && in_last)
                         - CW'(out_valid && out_ready && out_last);
      if (out_valid && out_ready) mid_pkt <= !out_last;
    end
  end

  a_r3_no_early_word: assert property (@(posedge clk) disable iff (reset)
    out_valid |-> pending != '0);

  a_r4_prompt_release: assert property (@(posedge clk) disable iff (reset)
    (pending != '0) |-> out_valid);

  a_r2_last_after_header: assert property (@(posedge clk) disable iff (reset)
    (out_valid && out_last) |-> mid_pkt);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (reset)
    (out_valid && !out_ready && !clear) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (reset)
    clear |=> (!out_valid && in_ready));
endmodule

bind pkt_framer pkt_framer_chk #(.DATA_W(DATA_W), .HDR_AW(HDR_AW)) u_chk (
  .clk(clk), .reset(reset), .clear(clear), .in_last(in_last),
  .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
  .out_last(out_last), .out_valid(out_valid), .out_ready(out_ready));

// File: tb/test_pkt_framer.sv
module test_pkt_framer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int BAW = 3;
  localparam int HAW = 2;
  localparam int BDEPTH = 1 << BAW;
  localparam int HDEPTH = 1 << HAW;

  logic clk = 0, reset = 1, clear = 0;
  logic [DW-1:0] in_data = '0, in_hdr = '0, out_data;
  logic in_last = 0, in_valid = 0, in_ready, out_last, out_valid, out_ready = 0;

  pkt_framer #(.DATA_W(DW), .BODY_AW(BAW), .HDR_AW(HAW)) i_pkt_framer (
    .clk(clk), .reset(reset), .clear(clear), .in_data(in_data), .in_hdr(in_hdr),
    .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_last(out_last), .out_valid(out_valid),
    .out_ready(out_ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, last_acc_cyc = 0;
  int ready_mode = 2;
  bit gap_mode = 0, mon_first = 1, prev_stall = 0, prev_clear = 0;
  logic [DW:0] prev_word;
  logic [DW:0] exp_q[$];
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] hdr_of(int id, int len);
    return {32'hC0DE0000 | 32'(id), 32'(len)};
  endfunction
  function automatic logic [DW-1:0] body_of(int id, int idx);
    return {32'(id) ^ 32'h00FF0000, 32'(idx) ^ 32'h5A5A0000};
  endfunction

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_mode)
      0: out_ready = 1;
      1: out_ready = lfsr[0] | lfsr[3];
      default: out_ready = 0;
    endcase
  end

  always begin
    @(negedge clk);
    #3;
    if (!reset) begin
      if (prev_stall && !prev_clear)
        chk(out_valid && {out_last, out_data} == prev_word, "R8 hold",
            {out_last, out_data}, prev_word);
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3 early word", {out_last, out_data}, '0);
        end else if (out_ready) begin
          if (mon_first) begin
            chk({out_last, out_data} == exp_q[0], "R1 header", {out_last, out_data}, exp_q[0]);
            if (gap_mode)
              chk(cyc - last_acc_cyc == 1, "R4 latency", (DW+1)'(cyc - last_acc_cyc), 1);
          end else begin
            chk(out_data == exp_q[0][DW-1:0], "R5 body order", {out_last, out_data}, exp_q[0]);
            chk(out_last == exp_q[0][DW], "R2 last flag", (DW+1)'(out_last), (DW+1)'(exp_q[0][DW]));
          end
          void'(exp_q.pop_front());
          mon_first = out_last;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_word  = {out_last, out_data};
      prev_clear = clear;
    end
  end

  task automatic send_beat(input logic [DW-1:0] d, input logic [DW-1:0] h, input bit last,
                           input int maxwait, output bit ok);
    @(negedge clk);
    in_valid = 1; in_data = d; in_hdr = h; in_last = last; ok = 0;
    for (int w = 0; w < maxwait; w++) begin
      #3;
      if (in_ready) begin ok = 1; break; end
      @(negedge clk);
    end
    if (!ok) in_valid = 0;
  endtask

  task automatic send_pkt(input int id, input int len, input int maxwait, output bit ok);
    for (int i = 0; i < len; i++) begin
      send_beat(body_of(id, i), hdr_of(id, len), i == len - 1, maxwait, ok);
      if (!ok) return;
    end
    last_acc_cyc = cyc;
    exp_q.push_back({1'b0, hdr_of(id, len)});
    for (int i = 0; i < len; i++) exp_q.push_back({i == len - 1, body_of(id, i)});
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic drain();
    for (int w = 0; w < 2000; w++) begin
      @(negedge clk); #4;
      if (exp_q.size() == 0 && !out_valid) break;
    end
  endtask

  initial begin
    bit ok;
    int acc;
    repeat (3) @(negedge clk);
    reset = 0;
    #3;
    chk(!out_valid, "R9 reset valid", (DW+1)'(out_valid), 0);
    chk(in_ready, "R9 reset ready", (DW+1)'(in_ready), 1);

    // R4 R3: isolated packets, every length that fits
    ready_mode = 0; gap_mode = 1;
    for (int len = 1; len <= BDEPTH; len++) begin
      send_pkt(len, len, 50, ok);
      idle_in();
      drain();
      repeat (3) @(negedge clk);
    end
    chk(exp_q.size() == 0, "R4 all released", (DW+1)'(exp_q.size()), 0);
    gap_mode = 0;

    // R5 R8: back-to-back with random stalls
    ready_mode = 1;
    for (int p = 0; p < 60; p++) send_pkt(100 + p, (p % BDEPTH) + 1, 500, ok);
    idle_in();
    drain();
    chk(exp_q.size() == 0, "R5 stream drained", (DW+1)'(exp_q.size()), 0);

    // R6: header queue full
    ready_mode = 2;
    repeat (2) @(negedge clk);
    acc = 0;
    for (int p = 0; p < HDEPTH + 2; p++) begin
      send_pkt(300 + p, 1, 5, ok);
      if (ok) acc++;
    end
    idle_in(); #3;
    chk(acc == HDEPTH, "R6 header queue limit", (DW+1)'(acc), (DW+1)'(HDEPTH));
    chk(!in_ready, "R6 ready low hdr full", (DW+1)'(in_ready), 0);
    ready_mode = 0;
    drain();

    // R6: body queue full
    ready_mode = 2;
    repeat (2) @(negedge clk);
    send_pkt(400, BDEPTH, 5, ok);
    idle_in(); #3;
    chk(ok, "R6 full body stored", (DW+1)'(ok), 1);
    chk(!in_ready, "R6 ready low body full", (DW+1)'(in_ready), 0);
    ready_mode = 0;
    drain();

    // R7: clear discards stored packets
    ready_mode = 2;
    repeat (2) @(negedge clk);
    send_pkt(500, 3, 20, ok);
    send_pkt(501, 3, 20, ok);
    idle_in();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
    #3;
    chk(!out_valid, "R7 valid after clear", (DW+1)'(out_valid), 0);
    chk(in_ready, "R7 ready after clear", (DW+1)'(in_ready), 1);
    exp_q.delete();
    mon_first = 1;
    ready_mode = 0;
    send_pkt(502, 2, 20, ok);
    idle_in();
    drain();
    chk(exp_q.size() == 0, "R7 fresh packet only", (DW+1)'(exp_q.size()), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule